// File: doc/BRIEF.md
# NAND Command and Address Decoder

This block is the device-side front end of a small-page NAND flash array. It watches the shared 8-bit I/O bus and takes one byte on each rising edge of write enable while chip enable is low. The two latch-enable inputs tag the byte as a command or an address byte. It matches the one-, two- and three-command sequences of the array's operations and builds the column and row from the address bytes that follow them. For each completed operation it gives a one-cycle strobe with an operation code, the page-register column, the 17-bit page row and the plane. A busy input limits which commands are accepted while the array is working. Data bytes pass through untouched and are not decoded here.

The page register is 528 bytes long. A read can start in three regions: the low 256 bytes, the high 256 bytes, or the 16-byte spare area at columns 512 to 527. The start region is set by the command that opens the read. The high-half selection lasts for one access only and then falls back to the low half. The write-enable pin is sampled on the system clock, and a rise is detected by comparing it with its value one cycle earlier. Every output is registered one clock after the cycle in which the rise is seen.

Sequencer states: `ST_IDLE`, `ST_RD_ADDR` (collecting read or copy-source address), `ST_RD_DONE` (source read issued, may continue to copy-back), `ST_CB_ADDR` and `ST_CB_WAIT` (copy target address, then waiting for commit), `ST_PG_ADDR` and `ST_PG_WAIT` (program address, then data and commit), `ST_ER_ADDR` and `ST_ER_WAIT` (erase rows, then more groups or confirm). Transitions:
- 00h, 01h, 50h and 03h lead to `ST_RD_ADDR`.
- The fourth address byte moves `ST_RD_ADDR` to `ST_RD_DONE`.
- 8Ah moves `ST_RD_DONE` to `ST_CB_ADDR`, and four address bytes then lead to `ST_CB_WAIT`.
- 80h leads to `ST_PG_ADDR`, and four address bytes then lead to `ST_PG_WAIT`.
- 60h leads to `ST_ER_ADDR`, and three address bytes then lead to `ST_ER_WAIT`.
- A commit (10h, 11h or D0h), read ID, reset and any illegal byte all return to `ST_IDLE`.
- Status commands leave the state as it is.

Top module: `nand_cmd_decoder`

## Requirements
- R1: A byte is taken only on a low-to-high change of `we_n` seen while `ce_n` is low. It is a command when only `cle` is high and an address when only `ale` is high. With both or neither high it is ignored, and the sequence in progress carries on unchanged.
- R2: Single commands pulse `op_valid` for one cycle, one clock after the rise is detected. The codes are: FFh gives code 3 (reset), 70h gives 4 (status), 71h gives 5 (multi-plane status) and 90h gives 2 (identify). FFh also abandons any open sequence and sets the start region to 0. `op_code` is 0 whenever `op_valid` is low.
- R3: 00h, 01h or 50h followed by four address bytes gives code 1 (read) on the fourth byte. The address bytes are the column byte and then row bytes lowest first. `op_row` is the three row bytes joined and cut to 17 bits.
- R4: `start_region` is 0 after 00h, 1 after 01h and 2 after 50h. `op_col` is the column byte in region 0, 256 plus the byte in region 1, and 512 plus the byte's low 4 bits in region 2.
- R5: Once a read, program or copy-back started under region 1 is issued, `start_region` returns to 0. Region 2 stays selected.
- R6: 80h, four address bytes, any number of data bytes, then 10h gives code 6 (program). Ending with 11h instead gives code 7 (dummy multi-plane program stage).
- R7: 00h plus four address bytes issues code 1. Then 8Ah plus four address bytes plus 10h gives code 8 (copy-back). The form that starts with 03h and ends with 11h gives code 9. A commit byte that does not match the opening command is illegal.
- R8: 60h plus three row bytes plus D0h gives code 10 (erase) with `op_col` 0. Two or more 60h-plus-rows groups before D0h give code 11 (multi-plane erase), and the row is taken from the last group.
- R9: `op_plane` equals row bits [6:5], the two lowest block-address bits, on every address-carrying operation.
- R10: Any of the following pulses `err_illegal` for one cycle and returns the sequencer to idle:
  - a command byte outside the set 00h, 01h, 03h, 10h, 11h, 50h, 60h, 70h, 71h, 80h, 8Ah, 90h, D0h, FFh;
  - 10h, 11h, D0h or 8Ah arriving outside the state that expects it.
- R11: While `busy` is high, only 70h, 71h and FFh are acted on. Any other command byte pulses `err_busy` and changes nothing. Address bytes are dropped without an error.
- R12: 70h or 71h in the middle of a sequence reports status and leaves the sequence and its collected address intact.
- R13: After reset, `op_valid`, `op_code`, both error flags and `start_region` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable; a byte is taken on its rise |
| cle | input | 1 | High marks a command byte |
| ale | input | 1 | High marks an address byte |
| io | input | 8 | Shared command/address/data bus |
| busy | input | 1 | Array busy; restricts accepted commands |
| op_valid | output | 1 | One-cycle strobe for a decoded operation |
| op_code | output | 4 | Operation code (see R2 to R8) |
| op_col | output | 10 | Page-register column, 0 to 527 |
| op_row | output | 17 | Page row address |
| op_plane | output | 2 | Plane of the addressed block |
| start_region | output | 2 | Current read start region: 0 low, 1 high, 2 spare |
| err_illegal | output | 1 | One-cycle pulse on an illegal or misplaced command |
| err_busy | output | 1 | One-cycle pulse on a command refused while busy |

## Verification
The bench uses the defaults: a 17-bit row, 5 page bits per block and 2 plane bits. With these values the third row byte adds only its lowest bit to the row. The checks use row bytes with upper bits set to confirm the cut to 17 bits, and the plane is found at row bits [6:5], so a row byte of 40h selects plane 2. Every start region, both program endings, both copy-back forms, single and chained erase, busy refusal, and mid-sequence status and reset are driven with known column and row values.

// File: rtl/nand_dec_pkg.sv
package nand_dec_pkg;

    localparam int COL_W = 10;

    typedef enum logic [3:0] {
        OP_NONE       = 4'd0,
        OP_READ       = 4'd1,
        OP_READ_ID    = 4'd2,
        OP_RESET      = 4'd3,
        OP_STATUS     = 4'd4,
        OP_MP_STATUS  = 4'd5,
        OP_PROG       = 4'd6,
        OP_PROG_DUMMY = 4'd7,
        OP_COPY       = 4'd8,
        OP_COPY_DUMMY = 4'd9,
        OP_ERASE      = 4'd10,
        OP_MP_ERASE   = 4'd11
    } nand_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_ADDR, ST_RD_DONE, ST_CB_ADDR, ST_CB_WAIT,
        ST_PG_ADDR, ST_PG_WAIT, ST_ER_ADDR, ST_ER_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_PLAIN, SRC_CB_TRUE, SRC_CB_DUMMY
    } src_kind_e;

    localparam logic [1:0] RGN_LOW   = 2'd0;
    localparam logic [1:0] RGN_HIGH  = 2'd1;
    localparam logic [1:0] RGN_SPARE = 2'd2;

    localparam logic [7:0] CMD_PTR_LOW   = 8'h00;
    localparam logic [7:0] CMD_PTR_HIGH  = 8'h01;
    localparam logic [7:0] CMD_CB_SRC_DM = 8'h03;
    localparam logic [7:0] CMD_COMMIT    = 8'h10;
    localparam logic [7:0] CMD_STAGE     = 8'h11;
    localparam logic [7:0] CMD_PTR_SPARE = 8'h50;
    localparam logic [7:0] CMD_ERASE     = 8'h60;
    localparam logic [7:0] CMD_STATUS    = 8'h70;
    localparam logic [7:0] CMD_MP_STATUS = 8'h71;
    localparam logic [7:0] CMD_PROG      = 8'h80;
    localparam logic [7:0] CMD_CB_PROG   = 8'h8A;
    localparam logic [7:0] CMD_READ_ID   = 8'h90;
    localparam logic [7:0] CMD_ERASE_GO  = 8'hD0;
    localparam logic [7:0] CMD_RESET     = 8'hFF;

endpackage

// File: rtl/nand_byte_capture.sv
module nand_byte_capture (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       we_n,
    input  logic       cle,
    input  logic       ale,
    output logic       cmd_stb,
    output logic       addr_stb
);
    logic we_q;
    logic rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_n;
    end

    assign rise     = we_n && !we_q && !ce_n;
    assign cmd_stb  = rise && cle && !ale;
    assign addr_stb = rise && ale && !cle;
endmodule

// File: rtl/nand_addr_collect.sv
module nand_addr_collect #(
    parameter int ROW_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             skip_col,
    input  logic             addr_stb,
    input  logic [7:0]       din,
    output logic [2:0]       fill,
    output logic [7:0]       col_byte,
    output logic [ROW_W-1:0] row
);
    localparam int SLOTS = 4;

    logic [7:0] slot_q [SLOTS];
    logic [7:0] slot_n [SLOTS];
    logic [2:0] cnt_q;
    logic       skip_q;
    logic [2:0] idx;
    logic       take;
    logic [23:0] row_full;

    assign idx  = cnt_q + {2'b00, skip_q};
    assign take = addr_stb && (idx < 3'(SLOTS));
    assign fill = cnt_q + {2'b00, take};

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign slot_n[i] = (take && idx == 3'(i)) ? din : slot_q[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     slot_q[i] <= 8'h00;
            else if (clear) slot_q[i] <= 8'h00;
            else            slot_q[i] <= slot_n[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= 3'd0;
            skip_q <= 1'b0;
        end else if (clear) begin
            cnt_q  <= 3'd0;
            skip_q <= skip_col;
        end else if (take) begin
            cnt_q  <= cnt_q + 3'd1;
        end
    end

    assign col_byte = slot_n[0];
    assign row_full = {slot_n[3], slot_n[2], slot_n[1]};
    assign row      = row_full[ROW_W-1:0];
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_dec_pkg::*;
#(
    parameter int ROW_W      = 17,
    parameter int PAGE_BITS  = 5,
    parameter int PLANE_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_stb,
    input  logic                  addr_stb,
    input  logic [7:0]            din,
    input  logic                  busy,
    input  logic [2:0]            fill,
    input  logic [7:0]            col_byte,
    input  logic [ROW_W-1:0]      row,
    output logic                  clr,
    output logic                  skip,
    output logic                  op_valid,
    output logic [3:0]            op_code,
    output logic [COL_W-1:0]      op_col,
    output logic [ROW_W-1:0]      op_row,
    output logic [PLANE_BITS-1:0] op_plane,
    output logic [1:0]            start_region,
    output logic                  err_illegal,
    output logic                  err_busy
);
    localparam logic [PLANE_BITS-1:0] GRP_MAX = '1;

    seq_state_e            state_q, state_n;
    src_kind_e             src_q, src_n;
    logic [1:0]            ptr_q, ptr_n, sreg_q, sreg_n;
    logic [PLANE_BITS-1:0] grp_q, grp_n;
    logic                  emit, ill, bsy, revert;
    nand_op_e              code;
    logic [COL_W-1:0]      col_map;

    always_comb begin
        state_n = state_q; src_n = src_q; ptr_n = ptr_q; sreg_n = sreg_q; grp_n = grp_q;
        clr = 1'b0; skip = 1'b0; emit = 1'b0; code = OP_NONE;
        ill = 1'b0; bsy = 1'b0; revert = 1'b0;
        if (cmd_stb) begin
            if (busy && !(din inside {CMD_STATUS, CMD_MP_STATUS, CMD_RESET})) begin
                bsy = 1'b1;
            end else begin
                unique case (din)
                    CMD_RESET:     begin emit = 1'b1; code = OP_RESET; state_n = ST_IDLE; ptr_n = RGN_LOW; end
                    CMD_STATUS:    begin emit = 1'b1; code = OP_STATUS; end
                    CMD_MP_STATUS: begin emit = 1'b1; code = OP_MP_STATUS; end
                    CMD_READ_ID:   begin emit = 1'b1; code = OP_READ_ID; state_n = ST_IDLE; end
                    CMD_PTR_LOW, CMD_PTR_HIGH, CMD_PTR_SPARE: begin
                        ptr_n   = (din == CMD_PTR_LOW)  ? RGN_LOW :
                                  (din == CMD_PTR_HIGH) ? RGN_HIGH : RGN_SPARE;
                        sreg_n  = ptr_n;
                        src_n   = (din == CMD_PTR_LOW) ? SRC_CB_TRUE : SRC_PLAIN;
                        clr     = 1'b1;
                        state_n = ST_RD_ADDR;
                    end
                    CMD_CB_SRC_DM: begin
                        sreg_n = RGN_LOW; src_n = SRC_CB_DUMMY; clr = 1'b1; state_n = ST_RD_ADDR;
                    end
                    CMD_PROG: begin
                        sreg_n = ptr_q; src_n = SRC_PLAIN; clr = 1'b1; state_n = ST_PG_ADDR;
                    end
                    CMD_CB_PROG: begin
                        if (state_q == ST_RD_DONE && src_q != SRC_PLAIN) begin
                            clr = 1'b1; state_n = ST_CB_ADDR;
                        end else ill = 1'b1;
                    end
                    CMD_COMMIT: begin
                        if (state_q == ST_PG_WAIT) begin
                            emit = 1'b1; code = OP_PROG; state_n = ST_IDLE;
                        end else if (state_q == ST_CB_WAIT && src_q == SRC_CB_TRUE) begin
                            emit = 1'b1; code = OP_COPY; state_n = ST_IDLE;
                        end else ill = 1'b1;
                    end
                    CMD_STAGE: begin
                        if (state_q == ST_PG_WAIT) begin
                            emit = 1'b1; code = OP_PROG_DUMMY; state_n = ST_IDLE;
                        end else if (state_q == ST_CB_WAIT && src_q == SRC_CB_DUMMY) begin
                            emit = 1'b1; code = OP_COPY_DUMMY; state_n = ST_IDLE;
                        end else ill = 1'b1;
                    end
                    CMD_ERASE: begin
                        if (state_q == ST_ER_WAIT) grp_n = (grp_q == GRP_MAX) ? grp_q : grp_q + 1'b1;
                        else                       grp_n = '0;
                        clr = 1'b1; skip = 1'b1; state_n = ST_ER_ADDR;
                    end
                    CMD_ERASE_GO: begin
                        if (state_q == ST_ER_WAIT) begin
                            emit = 1'b1; state_n = ST_IDLE;
                            code = (grp_q == '0) ? OP_ERASE : OP_MP_ERASE;
                        end else ill = 1'b1;
                    end
                    default: ill = 1'b1;
                endcase
                if (ill) state_n = ST_IDLE;
                if (emit && code inside {OP_PROG, OP_PROG_DUMMY, OP_COPY, OP_COPY_DUMMY}
                    && sreg_q == RGN_HIGH) revert = 1'b1;
            end
        end else if (addr_stb && !busy) begin
            unique case (state_q)
                ST_RD_ADDR: if (fill == 3'd4) begin
                    emit = 1'b1; code = OP_READ; state_n = ST_RD_DONE;
                    revert = (sreg_q == RGN_HIGH);
                end
                ST_CB_ADDR: if (fill == 3'd4) state_n = ST_CB_WAIT;
                ST_PG_ADDR: if (fill == 3'd4) state_n = ST_PG_WAIT;
                ST_ER_ADDR: if (fill == 3'd3) state_n = ST_ER_WAIT;
                default: ;
            endcase
        end
        if (revert) ptr_n = RGN_LOW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; src_q <= SRC_PLAIN;
            ptr_q <= RGN_LOW; sreg_q <= RGN_LOW; grp_q <= '0;
        end else begin
            state_q <= state_n; src_q <= src_n;
            ptr_q <= ptr_n; sreg_q <= sreg_n; grp_q <= grp_n;
        end
    end

    always_comb begin
        unique case (sreg_q)
            RGN_HIGH:  col_map = {2'b01, col_byte};
            RGN_SPARE: col_map = {2'b10, 4'b0000, col_byte[3:0]};
            default:   col_map = {2'b00, col_byte};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_valid <= 1'b0; op_code <= 4'd0; op_col <= '0; op_row <= '0;
            op_plane <= '0; err_illegal <= 1'b0; err_busy <= 1'b0;
        end else begin
            op_valid    <= emit;
            op_code     <= code;
            err_illegal <= ill;
            err_busy    <= bsy;
            if (emit && code inside {OP_READ, OP_PROG, OP_PROG_DUMMY, OP_COPY,
                                     OP_COPY_DUMMY, OP_ERASE, OP_MP_ERASE}) begin
                op_col   <= (code inside {OP_ERASE, OP_MP_ERASE}) ? '0 : col_map;
                op_row   <= row;
                op_plane <= row[PAGE_BITS +: PLANE_BITS];
            end
        end
    end

    assign start_region = ptr_q;
endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder #(
    parameter int ROW_W      = 17,
    parameter int PAGE_BITS  = 5,
    parameter int PLANE_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce_n,
    input  logic                  we_n,
    input  logic                  cle,
    input  logic                  ale,
    input  logic [7:0]            io,
    input  logic                  busy,
    output logic                  op_valid,
    output logic [3:0]            op_code,
    output logic [9:0]            op_col,
    output logic [ROW_W-1:0]      op_row,
    output logic [PLANE_BITS-1:0] op_plane,
    output logic [1:0]            start_region,
    output logic                  err_illegal,
    output logic                  err_busy
);
    logic             cmd_stb, addr_stb, addr_ok, clr, skip;
    logic [2:0]       fill;
    logic [7:0]       col_byte;
    logic [ROW_W-1:0] row;

    nand_byte_capture u_cap (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .cle(cle), .ale(ale), .cmd_stb(cmd_stb), .addr_stb(addr_stb)
    );

    assign addr_ok = addr_stb && !busy;

    nand_addr_collect #(.ROW_W(ROW_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clear(clr), .skip_col(skip),
        .addr_stb(addr_ok), .din(io), .fill(fill), .col_byte(col_byte), .row(row)
    );

    nand_seq_fsm #(.ROW_W(ROW_W), .PAGE_BITS(PAGE_BITS), .PLANE_BITS(PLANE_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .addr_stb(addr_ok), .din(io),
        .busy(busy), .fill(fill), .col_byte(col_byte), .row(row), .clr(clr), .skip(skip),
        .op_valid(op_valid), .op_code(op_code), .op_col(op_col), .op_row(op_row),
        .op_plane(op_plane), .start_region(start_region),
        .err_illegal(err_illegal), .err_busy(err_busy)
    );
endmodule

// File: rtl/nand_cmd_decoder_chk.sv
module nand_cmd_decoder_chk #(
    parameter int ROW_W      = 17,
    parameter int PAGE_BITS  = 5,
    parameter int PLANE_BITS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ce_n,
    input logic                  busy,
    input logic                  op_valid,
    input logic [3:0]            op_code,
    input logic [9:0]            op_col,
    input logic [ROW_W-1:0]      op_row,
    input logic [PLANE_BITS-1:0] op_plane,
    input logic [1:0]            start_region,
    input logic                  err_illegal,
    input logic                  err_busy
);
    a_r2_code_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> op_code == 4'd0);
    a_r2_strobe_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> op_code != 4'd0);
    a_r1_needs_chip_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid || err_illegal || err_busy) |-> $past(!ce_n));
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_valid, err_illegal, err_busy}));
    a_r11_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_busy |-> $past(busy));
    a_r11_busy_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && $past(busy)) |-> (op_code inside {4'd3, 4'd4, 4'd5}));
    a_r9_plane_from_row: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code inside {4'd1, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11}))
        |-> op_plane == op_row[PAGE_BITS +: PLANE_BITS]);
    a_r8_erase_no_column: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code inside {4'd10, 4'd11})) |-> op_col == 10'd0);
    a_r4_region_legal: assert property (@(posedge clk) disable iff (!rst_n)
        start_region != 2'd3);
    a_r4_column_range: assert property (@(posedge clk) disable iff (!rst_n)
        op_col < 10'd528);
endmodule

bind nand_cmd_decoder nand_cmd_decoder_chk #(
    .ROW_W(ROW_W), .PAGE_BITS(PAGE_BITS), .PLANE_BITS(PLANE_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .busy(busy), .op_valid(op_valid),
    .op_code(op_code), .op_col(op_col), .op_row(op_row), .op_plane(op_plane),
    .start_region(start_region), .err_illegal(err_illegal), .err_busy(err_busy)
);

// File: tb/nand_cmd_decoder_test.sv
module nand_cmd_decoder_test;
    localparam int ROW_W = 17;
    localparam logic [1:0] K_C = 2'd0, K_A = 2'd1, K_D = 2'd2, K_B = 2'd3;
    localparam int NV = 64;
    // {kind, byte, busy, exp_valid, exp_code, exp_illegal, exp_busy}
    localparam logic [17:0] VEC [NV] = '{
        {K_C,8'hFF,1'b0,1'b1,4'd3,1'b0,1'b0},  {K_C,8'h70,1'b0,1'b1,4'd4,1'b0,1'b0},
        {K_C,8'h71,1'b0,1'b1,4'd5,1'b0,1'b0},  {K_C,8'h90,1'b0,1'b1,4'd2,1'b0,1'b0},
        {K_C,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h10,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h20,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h30,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h00,1'b0,1'b1,4'd1,1'b0,1'b0},  {K_C,8'h80,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h01,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h02,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h03,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_D,8'h55,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_C,8'h70,1'b0,1'b1,4'd4,1'b0,1'b0},
        {K_C,8'h10,1'b0,1'b1,4'd6,1'b0,1'b0},  {K_C,8'h80,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_C,8'h11,1'b0,1'b1,4'd7,1'b0,1'b0},  {K_C,8'h60,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h20,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_C,8'hD0,1'b0,1'b1,4'd10,1'b0,1'b0},
        {K_C,8'h60,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_C,8'h60,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h20,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_C,8'hD0,1'b0,1'b1,4'd11,1'b0,1'b0}, {K_C,8'h10,1'b0,1'b0,4'd0,1'b1,1'b0},
        {K_C,8'h42,1'b0,1'b0,4'd0,1'b1,1'b0},  {K_C,8'h80,1'b1,1'b0,4'd0,1'b0,1'b1},
        {K_C,8'h70,1'b1,1'b1,4'd4,1'b0,1'b0},  {K_C,8'hFF,1'b1,1'b1,4'd3,1'b0,1'b0},
        {K_C,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h00,1'b0,1'b1,4'd1,1'b0,1'b0},  {K_C,8'h8A,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_C,8'h10,1'b0,1'b1,4'd8,1'b0,1'b0},  {K_C,8'h03,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h00,1'b0,1'b1,4'd1,1'b0,1'b0},
        {K_C,8'h8A,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},
        {K_A,8'h00,1'b0,1'b0,4'd0,1'b0,1'b0},  {K_C,8'h11,1'b0,1'b1,4'd9,1'b0,1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b0, we_n = 1'b1, cle = 1'b0, ale = 1'b0, busy = 1'b0;
    logic [7:0] io = 8'h00;
    logic op_valid, err_illegal, err_busy;
    logic [3:0] op_code;
    logic [9:0] op_col;
    logic [ROW_W-1:0] op_row;
    logic [1:0] op_plane, start_region;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nand_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
        .io(io), .busy(busy), .op_valid(op_valid), .op_code(op_code), .op_col(op_col),
        .op_row(op_row), .op_plane(op_plane), .start_region(start_region),
        .err_illegal(err_illegal), .err_busy(err_busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // starts and ends at a falling clock edge; outputs are sampled after return
    task automatic send(input logic [1:0] k, input logic [7:0] b,
                        input logic bz = 1'b0, input logic ce = 1'b0);
        cle = (k == K_C) || (k == K_B);
        ale = (k == K_A) || (k == K_B);
        io = b; busy = bz; ce_n = ce; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic [3:0] c, input logic il, input logic bs);
        if (il) return "R10 illegal";
        if (bs) return "R11 busy";
        case (c)
            4'd1: return "R3 read";
            4'd2, 4'd3, 4'd4, 4'd5: return "R2 single";
            4'd6, 4'd7: return "R6 program";
            4'd8, 4'd9: return "R7 copy-back";
            4'd10, 4'd11: return "R8 erase";
            default: return "R1 no-op byte";
        endcase
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 op_valid", op_valid, 0);
        check("R13 op_code", op_code, 0);
        check("R13 err_illegal", err_illegal, 0);
        check("R13 err_busy", err_busy, 0);
        check("R13 start_region", start_region, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            v = VEC[i];
            send(v[17:16], v[15:8], v[7]);
            check({tag_of(v[5:2], v[1], v[0]), " valid"}, op_valid, v[6]);
            check({tag_of(v[5:2], v[1], v[0]), " code"}, op_code, v[5:2]);
            check({tag_of(v[5:2], v[1], v[0]), " illegal"}, err_illegal, v[1]);
            check({tag_of(v[5:2], v[1], v[0]), " busy"}, err_busy, v[0]);
        end

        // R3 R4 R9: region 0 read with row truncation
        send(K_C, 8'h00); check("R4 region low", start_region, 0);
        send(K_A, 8'h12); send(K_A, 8'h34); send(K_A, 8'h56); send(K_A, 8'h01);
        check("R3 read code", op_code, 1);
        check("R4 col low", op_col, 10'h012);
        check("R3 row", op_row, 17'h15634);
        check("R9 plane", op_plane, 1);

        // R4 R5: high half then revert
        send(K_C, 8'h01); check("R4 region high", start_region, 1);
        send(K_A, 8'h80); send(K_A, 8'h00); send(K_A, 8'h00); send(K_A, 8'h00);
        check("R4 col high", op_col, 10'h180);
        check("R5 revert after high read", start_region, 0);

        // R4 R5: spare stays selected
        send(K_C, 8'h50); check("R4 region spare", start_region, 2);
        send(K_A, 8'h2B); send(K_A, 8'h00); send(K_A, 8'h00); send(K_A, 8'h00);
        check("R4 col spare", op_col, 10'h20B);
        check("R5 spare persists", start_region, 2);
        send(K_C, 8'h00); check("R4 back to low", start_region, 0);

        // R5: program under high half reverts
        send(K_C, 8'h01); send(K_C, 8'h80);
        send(K_A, 8'h05); send(K_A, 8'h00); send(K_A, 8'h00); send(K_A, 8'h00);
        send(K_C, 8'h10);
        check("R6 program code", op_code, 6);
        check("R5 program col high", op_col, 10'h105);
        check("R5 revert after program", start_region, 0);

        // R8 R9: erase column and plane
        send(K_C, 8'h60); send(K_A, 8'h40); send(K_A, 8'h00); send(K_A, 8'h00);
        send(K_C, 8'hD0);
        check("R8 erase code", op_code, 10);
        check("R8 erase col", op_col, 0);
        check("R8 erase row", op_row, 17'h00040);
        check("R9 erase plane", op_plane, 2);

        // R1: chip enable high and dual-latch byte are ignored
        send(K_C, 8'hFF, 1'b0, 1'b1);
        check("R1 ce high ignored", op_valid, 0);
        send(K_C, 8'h80);
        send(K_A, 8'h00); send(K_A, 8'h00); send(K_A, 8'h00); send(K_A, 8'h00);
        send(K_B, 8'h10);
        check("R1 dual latch no op", op_valid, 0);
        check("R1 dual latch no error", err_illegal, 0);
        send(K_C, 8'h10);
        check("R1 sequence intact", op_code, 6);

        // R11: address dropped while busy
        send(K_C, 8'h00); send(K_A, 8'h01); send(K_A, 8'h02, 1'b1);
        check("R11 busy address no error", err_busy, 0);
        send(K_A, 8'h03); send(K_A, 8'h04); send(K_A, 8'h05);
        check("R11 read after busy addr", op_code, 1);
        check("R11 col", op_col, 10'h001);
        check("R11 row skips busy byte", op_row, 17'h10403);

        // R12: status mid-sequence
        send(K_C, 8'h00); send(K_A, 8'h07); send(K_A, 8'h08);
        send(K_C, 8'h71); check("R12 status code", op_code, 5);
        send(K_A, 8'h09); send(K_A, 8'h00);
        check("R12 read resumes", op_code, 1);
        check("R12 col kept", op_col, 10'h007);
        check("R12 row kept", op_row, 17'h00908);

        // R7: mismatched copy-back commit
        send(K_C, 8'h00);
        send(K_A, 8'h00); send(K_A, 8'h00); send(K_A, 8'h00); send(K_A, 8'h00);
        send(K_C, 8'h8A);
        send(K_A, 8'h00); send(K_A, 8'h00); send(K_A, 8'h00); send(K_A, 8'h00);
        send(K_C, 8'h11);
        check("R7 mismatch illegal", err_illegal, 1);
        check("R7 mismatch no op", op_valid, 0);

        // R2: reset aborts and restores low region
        send(K_C, 8'h01); send(K_A, 8'h00); send(K_A, 8'h00);
        send(K_C, 8'hFF);
        check("R2 reset code", op_code, 3);
        check("R2 reset region", start_region, 0);
        send(K_A, 8'h00); send(K_A, 8'h00); send(K_A, 8'h00); send(K_A, 8'h00);
        check("R2 aborted no read", op_valid, 0);

        summary();
    end
endmodule